// File: doc/BRIEF.md
# Programmable System Clock-Ratio Controller

This block decides how fast the processor core runs relative to the crystal. Software writes a two-bit divide code and a small mode register. From these the block selects one of four clock ratios: multiply-by-4, multiply-by-2, divide-by-1 or divide-by-1024. It reports the active ratio as a one-hot vector and produces a clock-enable pulse stream from a reference clock that runs at four times the crystal rate.

Several control bits guard one another. The multiplier can only be switched while the core runs at divide-by-1 and the ring oscillator is not in use. The 2x/4x choice is frozen while the multiplier is on. A multiplied ratio only takes hold after a startup timeout has raised the clock-ready flag. When the core idles at divide-by-1024 with switchback armed, an enabled external interrupt or a detected serial start bit drops the divide code back to divide-by-1 by hardware. Ratio changes are applied only at a pulse boundary, so no clock-enable period is ever shortened or stretched.

Top module: `clkdiv_ctrl`

## Requirements
- R1: After reset the divide code reads 10, all mode bits read 0, clk_ready is 0, ratio_sel is divide-by-1 and clk_en pulses once every 4 reference cycles.
- R2: Divide codes 10 and 01 both select divide-by-1. Code 11 selects divide-by-1024, with a pulse every SLOW_PERIOD reference cycles. Code 00 selects the multiplied clock.
- R3: ratio_sel is always one-hot, with bit0 for x4, bit1 for x2, bit2 for divide-by-1 and bit3 for divide-by-1024. The matching clk_en periods are 1, 2, 4 and SLOW_PERIOD reference cycles.
- R4: A write to the 2x/4x select bit is ignored whenever the multiplier enable bit held 1 before that write.
- R5: A write to the multiplier enable bit is ignored unless the divide code is 10 or 01 and ring_mode is 0.
- R6: Setting the multiplier enable bit from 0 to 1 clears clk_ready. clk_ready then rises between STARTUP_CYCLES and STARTUP_CYCLES+2 reference cycles later. Clearing the multiplier enable bit drops clk_ready within two cycles.
- R7: With code 00 the output stays at divide-by-1 until the multiplier is enabled and clk_ready is 1. It then becomes x4 if the select bit is 1 and x2 if it is 0. A multiplied ratio is never shown while clk_ready is 0.
- R8: With code 11 and the switchback bit set, a high ext_irq or ser_start makes the divide code read 10 on the next cycle. ratio_sel returns to divide-by-1 at the end of the slow period already in progress.
- R9: ext_irq and ser_start leave the divide code unchanged when the switchback bit is 0, or when the code is anything other than 11.
- R10: ratio_sel changes only in the cycle after a clk_en pulse.
- R11: The register map is as follows. wr_addr 0 writes the divide code from wr_data[1:0]. wr_addr 1 writes the mode register: bit0 is switchback enable, bit1 is multiplier enable and bit2 is 2x/4x select (1 means x4). div_rd and mode_rd return the held values with the same bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, four times the crystal rate |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the divide code, 1 selects the mode register |
| wr_data | input | 3 | Write data |
| ring_mode | input | 1 | High while the ring oscillator drives the core; blocks multiplier writes |
| ext_irq | input | 1 | An enabled external interrupt is pending |
| ser_start | input | 1 | A serial start bit has been detected |
| ratio_sel | output | 4 | One-hot active ratio |
| clk_en | output | 1 | Clock-enable pulse for the core |
| clk_ready | output | 1 | Multiplier startup timeout has elapsed |
| div_rd | output | 2 | Held divide code |
| mode_rd | output | 3 | Held mode register |

## Verification
A sequence of register writes runs each guard through both its permitted and its blocked case. The sequence also varies the ring-oscillator flag and the order in which divide code and multiplier bit are written, so an ignored write can be told apart from an accepted one. The ratio output is tried with every divide code, including the reserved one. Each is paired with period measurements of clk_en, which separate x4 from x2 from divide-by-1 and show whether a pending multiplied request leaks out before clk_ready. Switchback is fired by an interrupt and by a start bit in the slow mode. It is also fired with switchback disarmed and in other modes, which separates the armed path from the ignored ones. The return latency shows whether the ratio change waits for the running period to end.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    // divide code held in the divide register
    typedef enum logic [1:0] {
        DIV_MULT = 2'b00,
        DIV_RSVD = 2'b01,
        DIV_ONE  = 2'b10,
        DIV_SLOW = 2'b11
    } div_code_e;

    // one-hot active ratio
    typedef enum logic [3:0] {
        RATIO_X4   = 4'b0001,
        RATIO_X2   = 4'b0010,
        RATIO_D1   = 4'b0100,
        RATIO_SLOW = 4'b1000
    } ratio_e;

    // mode register, bit2..bit0
    typedef struct packed {
        logic x4_sel;
        logic mul_en;
        logic swb_en;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);
    localparam int DIV_W  = $bits(div_code_e);

    localparam logic REG_DIV  = 1'b0;
    localparam logic REG_MODE = 1'b1;

    // the reserved code behaves as divide-by-1
    function automatic logic is_div_one(div_code_e d);
        return (d == DIV_ONE) || (d == DIV_RSVD);
    endfunction

    // requested ratio from the held state
    function automatic ratio_e pick_ratio(div_code_e d, mode_t m, logic ready);
        ratio_e r;
        case (d)
            DIV_MULT: begin
                if (m.mul_en && ready)
                    r = m.x4_sel ? RATIO_X4 : RATIO_X2;
                else
                    r = RATIO_D1;
            end
            DIV_SLOW: r = RATIO_SLOW;
            default:  r = RATIO_D1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/clkdiv_regs.sv
`timescale 1ns/1ps
module clkdiv_regs
    import clkdiv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wr_addr,
    input  logic [MODE_W-1:0]    wr_data,
    input  logic                 ring_mode,
    input  logic                 ext_irq,
    input  logic                 ser_start,
    output div_code_e            div_q,
    output mode_t                mode_q,
    output logic                 mul_start
);

    mode_t wr_mode;
    logic  div_wr;
    logic  mode_wr;
    logic  swb_fire;
    logic  mul_ok;

    assign wr_mode  = mode_t'(wr_data);
    assign div_wr   = wr_en && (wr_addr == REG_DIV);
    assign mode_wr  = wr_en && (wr_addr == REG_MODE);
    assign swb_fire = (div_q == DIV_SLOW) && mode_q.swb_en && (ext_irq || ser_start);
    assign mul_ok   = is_div_one(div_q) && !ring_mode;

    // divide code: hardware switchback wins over a software write
    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= DIV_ONE;
        end else if (swb_fire) begin
            div_q <= DIV_ONE;
        end else if (div_wr) begin
            div_q <= div_code_e'(wr_data[DIV_W-1:0]);
        end
    end

    // mode register with per-bit guards taken from the pre-write state
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            mul_start <= 1'b0;
        end else begin
            mul_start <= 1'b0;
            if (mode_wr) begin
                mode_q.swb_en <= wr_mode.swb_en;
                if (!mode_q.mul_en) begin
                    mode_q.x4_sel <= wr_mode.x4_sel;
                end
                if (mul_ok) begin
                    mode_q.mul_en <= wr_mode.mul_en;
                    mul_start     <= wr_mode.mul_en && !mode_q.mul_en;
                end
            end
        end
    end

endmodule

// File: rtl/clkdiv_ready_timer.sv
`timescale 1ns/1ps
module clkdiv_ready_timer #(
    parameter int STARTUP_CYCLES = 65536
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic enable,
    output logic ready
);

    localparam int CW = $clog2(STARTUP_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(STARTUP_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          running;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
            ready   <= 1'b0;
        end else if (!enable) begin
            running <= 1'b0;
            ready   <= 1'b0;
        end else if (start) begin
            cnt     <= LOAD;
            running <= 1'b1;
            ready   <= 1'b0;
        end else if (running) begin
            if (cnt == '0) begin
                running <= 1'b0;
                ready   <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/clkdiv_pulse_gen.sv
`timescale 1ns/1ps
module clkdiv_pulse_gen
    import clkdiv_pkg::*;
#(
    parameter int SLOW_PERIOD = 4096
) (
    input  logic   clk,
    input  logic   rst,
    input  ratio_e target,
    output ratio_e active,
    output logic   clk_en
);

    localparam int PW = $clog2(SLOW_PERIOD);

    logic [PW-1:0] cnt;

    // reload value is period minus one
    function automatic logic [PW-1:0] reload(ratio_e r);
        logic [PW-1:0] v;
        case (r)
            RATIO_X4: v = PW'(0);
            RATIO_X2: v = PW'(1);
            RATIO_D1: v = PW'(3);
            default:  v = PW'(SLOW_PERIOD - 1);
        endcase
        return v;
    endfunction

    assign clk_en = (cnt == '0);

    // a new ratio is latched only when the running period ends
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= RATIO_D1;
        end else if (clk_en) begin
            cnt    <= reload(target);
            active <= target;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/clkdiv_ctrl.sv
`timescale 1ns/1ps
module clkdiv_ctrl
    import clkdiv_pkg::*;
#(
    parameter int STARTUP_CYCLES = 65536,
    parameter int SLOW_PERIOD    = 4096
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [2:0] wr_data,
    input  logic       ring_mode,
    input  logic       ext_irq,
    input  logic       ser_start,
    output logic [3:0] ratio_sel,
    output logic       clk_en,
    output logic       clk_ready,
    output logic [1:0] div_rd,
    output logic [2:0] mode_rd
);

    div_code_e div_q;
    mode_t     mode_q;
    logic      mul_start;
    ratio_e    target;
    ratio_e    active;

    clkdiv_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ring_mode (ring_mode),
        .ext_irq   (ext_irq),
        .ser_start (ser_start),
        .div_q     (div_q),
        .mode_q    (mode_q),
        .mul_start (mul_start)
    );

    clkdiv_ready_timer #(
        .STARTUP_CYCLES (STARTUP_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (mul_start),
        .enable (mode_q.mul_en),
        .ready  (clk_ready)
    );

    assign target = pick_ratio(div_q, mode_q, clk_ready);

    clkdiv_pulse_gen #(
        .SLOW_PERIOD (SLOW_PERIOD)
    ) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .target (target),
        .active (active),
        .clk_en (clk_en)
    );

    assign ratio_sel = active;
    assign div_rd    = div_q;
    assign mode_rd   = mode_q;

endmodule

// File: rtl/clkdiv_ctrl_chk.sv
`timescale 1ns/1ps
module clkdiv_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ring_mode,
    input logic       ext_irq,
    input logic       ser_start,
    input logic [3:0] ratio_sel,
    input logic       clk_en,
    input logic       clk_ready,
    input logic [1:0] div_rd,
    input logic [2:0] mode_rd
);

    // R3
    ratio_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(ratio_sel) == 1);

    // R10
    ratio_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ratio_sel) |-> $past(clk_en));

    // R7
    mult_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (ratio_sel[0] || ratio_sel[1]) |-> clk_ready);

    // R4
    sel_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        $past(mode_rd[1]) |-> $stable(mode_rd[2]));

    // R5
    mul_guard_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_rd[1]) |-> $past((div_rd[1] ^ div_rd[0]) && !ring_mode));

    // R8
    switchback_chk: assert property (@(posedge clk) disable iff (rst)
        (div_rd == 2'b11 && mode_rd[0] && (ext_irq || ser_start)) |=> div_rd == 2'b10);

endmodule

bind clkdiv_ctrl clkdiv_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ring_mode (ring_mode),
    .ext_irq   (ext_irq),
    .ser_start (ser_start),
    .ratio_sel (ratio_sel),
    .clk_en    (clk_en),
    .clk_ready (clk_ready),
    .div_rd    (div_rd),
    .mode_rd   (mode_rd)
);

// File: tb/tb_clkdiv_ctrl.sv
`timescale 1ns/1ps
module tb_clkdiv_ctrl;

    localparam int N_START = 40;
    localparam int N_SLOW  = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [2:0] wr_data = '0;
    logic       ring_mode = 1'b0;
    logic       ext_irq = 1'b0;
    logic       ser_start = 1'b0;
    logic [3:0] ratio_sel;
    logic       clk_en;
    logic       clk_ready;
    logic [1:0] div_rd;
    logic [2:0] mode_rd;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    clkdiv_ctrl #(
        .STARTUP_CYCLES (N_START),
        .SLOW_PERIOD    (N_SLOW)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ring_mode (ring_mode),
        .ext_irq   (ext_irq),
        .ser_start (ser_start),
        .ratio_sel (ratio_sel),
        .clk_en    (clk_en),
        .clk_ready (clk_ready),
        .div_rd    (div_rd),
        .mode_rd   (mode_rd)
    );

    // {addr, data[2:0], ring, exp div[1:0], exp mul, exp x4, exp swb}
    localparam int NV = 12;
    localparam logic [9:0] VEC [NV] = '{
        10'b1_101_0_10_0_1_1,
        10'b0_011_0_11_0_1_1,
        10'b1_011_0_11_0_0_1,
        10'b0_001_0_01_0_0_1,
        10'b1_111_1_01_0_1_1,
        10'b1_111_0_01_1_1_1,
        10'b1_011_0_01_1_1_1,
        10'b0_000_0_00_1_1_1,
        10'b1_001_0_00_1_1_1,
        10'b0_010_0_10_1_1_1,
        10'b1_000_0_10_0_1_0,
        10'b1_000_0_10_0_0_0
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [2:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(output int p);
        int guard;
        guard = 0;
        while (!clk_en && guard < 10000) begin
            @(negedge clk);
            guard++;
        end
        p = 0;
        do begin
            @(negedge clk);
            p++;
        end while (!clk_en && p < 10000);
    endtask

    task automatic settle(output int p);
        int dummy;
        measure(dummy);
        measure(p);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int p;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(div_rd == 2'b10, "R1 div", div_rd, 2);
        chk(mode_rd == 3'b000, "R1 mode", mode_rd, 0);
        chk(clk_ready == 1'b0, "R1 ready", clk_ready, 0);
        chk(ratio_sel == 4'b0100, "R1 ratio", ratio_sel, 4);
        measure(p);
        chk(p == 4, "R1 R3 period", p, 4);

        // R11 R4 R5 guarded writes from the table
        for (int i = 0; i < NV; i++) begin
            ring_mode = VEC[i][5];
            wr(VEC[i][9], VEC[i][8:6]);
            chk(div_rd == VEC[i][4:3], "R11 R5 div", div_rd, VEC[i][4:3]);
            chk(mode_rd[1] == VEC[i][2], "R5 mul_en", mode_rd[1], VEC[i][2]);
            chk(mode_rd[2] == VEC[i][1], "R4 x4_sel", mode_rd[2], VEC[i][1]);
            chk(mode_rd[0] == VEC[i][0], "R11 swb", mode_rd[0], VEC[i][0]);
        end
        ring_mode = 1'b0;

        // R2 reserved code behaves as divide-by-1
        wr(1'b0, 3'b001);
        settle(p);
        chk(p == 4, "R2 reserved period", p, 4);
        chk(ratio_sel == 4'b0100, "R2 reserved ratio", ratio_sel, 4);
        wr(1'b0, 3'b010);

        // R6 startup timeout
        wr(1'b1, 3'b110);
        chk(clk_ready == 1'b0, "R6 ready cleared", clk_ready, 0);
        n = 0;
        while (!clk_ready && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk(n >= N_START && n <= N_START + 2, "R6 timeout", n, N_START);

        // R7 R3 x4 ratio
        wr(1'b0, 3'b000);
        settle(p);
        chk(p == 1, "R3 x4 period", p, 1);
        chk(ratio_sel == 4'b0001, "R7 x4 ratio", ratio_sel, 1);

        // R6 clearing the multiplier drops ready
        wr(1'b0, 3'b010);
        settle(p);
        wr(1'b1, 3'b000);
        @(negedge clk);
        chk(clk_ready == 1'b0, "R6 ready drop", clk_ready, 0);

        // R7 pending multiplied request stays at divide-by-1
        wr(1'b1, 3'b010);
        wr(1'b0, 3'b000);
        settle(p);
        chk(p == 4, "R7 pending period", p, 4);
        chk(ratio_sel == 4'b0100, "R7 pending ratio", ratio_sel, 4);
        chk(clk_ready == 1'b0, "R6 not yet ready", clk_ready, 0);
        n = 0;
        while (!clk_ready && n < 300) begin
            @(negedge clk);
            n++;
        end
        settle(p);
        chk(p == 2, "R3 x2 period", p, 2);
        chk(ratio_sel == 4'b0010, "R7 x2 ratio", ratio_sel, 2);
        wr(1'b0, 3'b010);
        wr(1'b1, 3'b000);

        // R2 R8 slow mode, switchback by interrupt
        wr(1'b1, 3'b001);
        wr(1'b0, 3'b011);
        settle(p);
        chk(p == N_SLOW, "R2 slow period", p, N_SLOW);
        chk(ratio_sel == 4'b1000, "R2 slow ratio", ratio_sel, 8);
        ext_irq = 1'b1;
        @(negedge clk);
        ext_irq = 1'b0;
        chk(div_rd == 2'b10, "R8 irq switchback", div_rd, 2);
        chk(ratio_sel == 4'b1000, "R10 ratio held", ratio_sel, 8);
        n = 0;
        while (ratio_sel != 4'b0100 && n < N_SLOW + 10) begin
            @(negedge clk);
            n++;
        end
        chk(n >= N_SLOW - 1 && n <= N_SLOW + 1, "R8 R10 return latency", n, N_SLOW);

        // R8 switchback by serial start bit
        wr(1'b0, 3'b011);
        settle(p);
        ser_start = 1'b1;
        @(negedge clk);
        ser_start = 1'b0;
        chk(div_rd == 2'b10, "R8 start switchback", div_rd, 2);
        settle(p);
        chk(ratio_sel == 4'b0100, "R8 start ratio", ratio_sel, 4);

        // R9 switchback disarmed
        wr(1'b1, 3'b000);
        wr(1'b0, 3'b011);
        ext_irq = 1'b1; ser_start = 1'b1;
        @(negedge clk);
        ext_irq = 1'b0; ser_start = 1'b0;
        @(negedge clk);
        chk(div_rd == 2'b11, "R9 disarmed", div_rd, 3);

        // R9 armed but not in slow mode
        wr(1'b1, 3'b001);
        wr(1'b0, 3'b000);
        ext_irq = 1'b1;
        @(negedge clk);
        ext_irq = 1'b0;
        @(negedge clk);
        chk(div_rd == 2'b00, "R9 code 00 kept", div_rd, 0);
        wr(1'b0, 3'b010);
        ser_start = 1'b1;
        @(negedge clk);
        ser_start = 1'b0;
        @(negedge clk);
        chk(div_rd == 2'b10, "R9 code 10 kept", div_rd, 2);

        // R1 reset mid-run from slow mode
        wr(1'b1, 3'b111);
        wr(1'b0, 3'b011);
        settle(p);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(div_rd == 2'b10, "R1 rerun div", div_rd, 2);
        chk(mode_rd == 3'b000, "R1 rerun mode", mode_rd, 0);
        chk(ratio_sel == 4'b0100, "R1 rerun ratio", ratio_sel, 4);
        chk(clk_ready == 1'b0, "R1 rerun ready", clk_ready, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule